// File: doc/BRIEF.md
# UART Byte Buffer Pair with Automatic RTS

This block holds the byte buffering that sits between a serial framer and the software-visible side of a UART. Received bytes from the framer go into a 32-entry receive queue, which software drains one byte at a time. Software loads bytes for transmission into a 16-entry transmit queue, which the framer drains through a valid/ready handshake. Both queues preserve order, and each can be emptied by its own flush pulse.

The block reports the receive occupancy and the free transmit space. It also produces two level indications: one that says the receive queue has gone above a programmed count, and one that says the transmit queue has dropped to or below a programmed count of bytes still pending. The request-to-send output (active low) is either computed from the receive occupancy against a programmed level, so that a remote sender is held off before the queue fills, or taken from a software bit.

A byte that cannot be stored is discarded, and a sticky flag records the loss for each direction. Only an explicit clear pulse drops these flags. The asynchronous reset input is synchronised inside the block, so the state leaves reset two clock edges after `rst_n` rises.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, `rx_level` is 0, `tx_space` is 16, `rx_ovf` and `tx_ovf` are 0, `tx_out_valid` is 0 and `rx_in_ready` is 1.
- R2: The receive queue stores up to 32 bytes in arrival order. `rx_level` (6 bits) counts the stored bytes, and `sw_rx_data` presents the oldest byte. A cycle that both pushes and pops leaves the level unchanged.
- R3: The transmit queue stores up to 16 bytes in push order. `tx_out_data` presents the oldest byte, and `tx_space` (5 bits) equals 16 minus the stored count.
- R4: `rx_avail` is 1 exactly when `rx_level` is greater than `rx_trig`. A `rx_trig` value of n therefore means that n+1 bytes are present.
- R5: `tx_need` is 1 exactly when the number of pending transmit bytes (16 minus `tx_space`) is less than or equal to `tx_trig`.
- R6: When `afc_en` is 1, `rts_n` is 1 (inactive) exactly when `rx_level` is greater than `afc_level`, and 0 otherwise.
- R7: When `afc_en` is 0, `rts_n` is the inverse of `sw_rts`.
- R8: A `rx_flush` or `tx_flush` pulse empties its queue in the following cycle. A push in the same cycle is ignored and does not set an overflow flag.
- R9: A `sw_tx_push` while the transmit queue holds 16 bytes discards the byte, leaves the queue contents unchanged and sets `tx_ovf`.
- R10: A `rx_in_valid` while the receive queue holds 32 bytes discards the byte, leaves the queue contents unchanged and sets `rx_ovf`.
- R11: Overflow flags stay set across flushes until an `ovf_clear` pulse. If a new overflow occurs in the same cycle as `ovf_clear`, the flag stays set.
- R12: A pop from an empty queue has no effect. `rx_in_ready` is 1 while the receive queue is not full, and `tx_out_valid` is 1 while the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally |
| rx_in_valid | input | 1 | Framer offers a received byte |
| rx_in_data | input | 8 | Received byte from the framer |
| rx_in_ready | output | 1 | Receive queue has room |
| tx_out_valid | output | 1 | Transmit queue has a byte for the framer |
| tx_out_data | output | 8 | Oldest transmit byte |
| tx_out_ready | input | 1 | Framer takes the transmit byte |
| sw_tx_push | input | 1 | Software writes a transmit byte |
| sw_tx_data | input | 8 | Byte written by software |
| sw_rx_pop | input | 1 | Software removes the oldest received byte |
| sw_rx_data | output | 8 | Oldest received byte |
| rx_level | output | 6 | Receive occupancy, 0 to 32 |
| tx_space | output | 5 | Free transmit entries, 0 to 16 |
| rx_flush | input | 1 | Empty the receive queue |
| tx_flush | input | 1 | Empty the transmit queue |
| ovf_clear | input | 1 | Clear both overflow flags |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_trig | input | 5 | Receive threshold |
| tx_trig | input | 4 | Transmit threshold |
| rx_avail | output | 1 | Receive level above threshold |
| tx_need | output | 1 | Pending transmit bytes at or below threshold |
| afc_en | input | 1 | Select automatic RTS |
| afc_level | input | 5 | Automatic RTS level |
| sw_rts | input | 1 | Software RTS request (1 means asserted) |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Every push, pop, flush or clear takes effect at the clock edge that samples it. The levels, data heads, ready/valid signals and overflow flags are read directly from registers, so each new value can be seen one edge after its stimulus. The bench drives its inputs just after a falling edge and checks at the next falling edge, which means a full edge has passed before each check. The threshold, flow-control and software-RTS outputs depend combinationally on their configuration inputs and on the stored levels. For each stored level, the bench sweeps every threshold value within the half period that holds no clock edge, and checks each setting after a small settling delay.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

  // Per-cycle queue operation after qualification
  typedef struct packed {
    logic wr;    // byte stored
    logic rd;    // byte removed
    logic clr;   // queue emptied
    logic lost;  // byte discarded for lack of room
  } ufp_op_t;

  function automatic int unsigned ufp_cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/ufp_rst_sync.sv
module ufp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/ufp_byte_fifo.sv
module ufp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  import ufp_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;
  ufp_op_t       op;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // Qualify the requested operations; flush dominates
  always_comb begin
    op.clr  = flush;
    op.wr   = push & ~full & ~flush;
    op.rd   = pop & ~empty & ~flush;
    op.lost = push & full & ~flush;
  end

  // Next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (op.clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (op.wr) wr_ptr_d = wr_ptr_q + AW'(1);
      if (op.rd) rd_ptr_d = rd_ptr_q + AW'(1);
      cnt_d = cnt_q + CW'(op.wr) - CW'(op.rd);
    end
  end

  assign upd_en = op.clr | op.wr | op.rd;

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (upd_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage, not reset
  always_ff @(posedge clk) begin
    if (op.wr) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;
  assign drop  = op.lost;

  // R2/R3: occupancy never passes the depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8: flush leaves the queue empty
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R10/R9: a discarded byte does not change occupancy
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R12: popping an empty queue leaves it empty
  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/ufp_flow_status.sv
module ufp_flow_status #(
  parameter int RX_DEPTH = 32,
  parameter int TX_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(RX_DEPTH+1)-1:0]   rx_count,
  input  logic [$clog2(TX_DEPTH+1)-1:0]   tx_count,
  input  logic [$clog2(RX_DEPTH)-1:0]     rx_trig,
  input  logic [$clog2(TX_DEPTH)-1:0]     tx_trig,
  input  logic                            afc_en,
  input  logic [$clog2(RX_DEPTH)-1:0]     afc_level,
  input  logic                            sw_rts,
  input  logic                            rx_drop,
  input  logic                            tx_drop,
  input  logic                            ovf_clear,
  output logic [$clog2(TX_DEPTH+1)-1:0]   tx_space,
  output logic                            rx_avail,
  output logic                            tx_need,
  output logic                            rts_n,
  output logic                            rx_ovf,
  output logic                            tx_ovf
);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);

  logic rx_ovf_q, rx_ovf_d;
  logic tx_ovf_q, tx_ovf_d;
  logic ovf_en;

  // Level indications
  always_comb begin
    tx_space = TCW'(TX_DEPTH) - tx_count;
    rx_avail = (rx_count > RCW'(rx_trig));
    tx_need  = (tx_count <= TCW'(tx_trig));
    if (afc_en) rts_n = (rx_count > RCW'(afc_level));
    else        rts_n = ~sw_rts;
  end

  // Sticky flags: a new loss beats a clear
  always_comb begin
    rx_ovf_d = rx_drop | (rx_ovf_q & ~ovf_clear);
    tx_ovf_d = tx_drop | (tx_ovf_q & ~ovf_clear);
  end

  assign ovf_en = rx_drop | tx_drop | ovf_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovf_q <= 1'b0;
      tx_ovf_q <= 1'b0;
    end else if (ovf_en) begin
      rx_ovf_q <= rx_ovf_d;
      tx_ovf_q <= tx_ovf_d;
    end
  end

  assign rx_ovf = rx_ovf_q;
  assign tx_ovf = tx_ovf_q;

  // R9: a transmit loss is flagged on the next cycle
  p_tx_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_ovf);

  // R10: a receive loss is flagged on the next cycle
  p_rx_ovf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_ovf);

  // R11: flags hold without a clear
  p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clear) |=> rx_ovf);

  // R11: a clear with no new loss drops the flag
  p_ovf_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !tx_drop) |=> !tx_ovf);

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int RX_DEPTH = 32,
  parameter int TX_DEPTH = 16,
  parameter int DW       = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_in_valid,
  input  logic [DW-1:0]                   rx_in_data,
  output logic                            rx_in_ready,
  output logic                            tx_out_valid,
  output logic [DW-1:0]                   tx_out_data,
  input  logic                            tx_out_ready,
  input  logic                            sw_tx_push,
  input  logic [DW-1:0]                   sw_tx_data,
  input  logic                            sw_rx_pop,
  output logic [DW-1:0]                   sw_rx_data,
  output logic [$clog2(RX_DEPTH+1)-1:0]   rx_level,
  output logic [$clog2(TX_DEPTH+1)-1:0]   tx_space,
  input  logic                            rx_flush,
  input  logic                            tx_flush,
  input  logic                            ovf_clear,
  output logic                            rx_ovf,
  output logic                            tx_ovf,
  input  logic [$clog2(RX_DEPTH)-1:0]     rx_trig,
  input  logic [$clog2(TX_DEPTH)-1:0]     tx_trig,
  output logic                            rx_avail,
  output logic                            tx_need,
  input  logic                            afc_en,
  input  logic [$clog2(RX_DEPTH)-1:0]     afc_level,
  input  logic                            sw_rts,
  output logic                            rts_n
);
  localparam int RCW = ufp_pkg::ufp_cnt_w(RX_DEPTH);
  localparam int TCW = ufp_pkg::ufp_cnt_w(TX_DEPTH);

  logic           rst_core_n;
  logic [RCW-1:0] rx_cnt;
  logic [TCW-1:0] tx_cnt;
  logic           rx_full, rx_empty, rx_drop;
  logic           tx_full, tx_empty, tx_drop;

  ufp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ufp_byte_fifo #(.DEPTH(RX_DEPTH), .W(DW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (rx_in_valid),
    .din   (rx_in_data),
    .pop   (sw_rx_pop),
    .flush (rx_flush),
    .dout  (sw_rx_data),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty),
    .drop  (rx_drop)
  );

  ufp_byte_fifo #(.DEPTH(TX_DEPTH), .W(DW)) u_txq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (sw_tx_push),
    .din   (sw_tx_data),
    .pop   (tx_out_ready),
    .flush (tx_flush),
    .dout  (tx_out_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty),
    .drop  (tx_drop)
  );

  ufp_flow_status #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_stat (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rx_count  (rx_cnt),
    .tx_count  (tx_cnt),
    .rx_trig   (rx_trig),
    .tx_trig   (tx_trig),
    .afc_en    (afc_en),
    .afc_level (afc_level),
    .sw_rts    (sw_rts),
    .rx_drop   (rx_drop),
    .tx_drop   (tx_drop),
    .ovf_clear (ovf_clear),
    .tx_space  (tx_space),
    .rx_avail  (rx_avail),
    .tx_need   (tx_need),
    .rts_n     (rts_n),
    .rx_ovf    (rx_ovf),
    .tx_ovf    (tx_ovf)
  );

  assign rx_level     = rx_cnt;
  assign rx_in_ready  = ~rx_full;
  assign tx_out_valid = ~tx_empty;

  // R3: free space and validity agree at the ports
  p_tx_space_valid_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_space == TCW'(TX_DEPTH)) |-> !tx_out_valid);

  // R1: state is empty on the first cycle out of reset
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (rx_level == '0 && !rx_ovf && !tx_ovf));

endmodule

// File: tb/uart_fifo_pair_tb_top.sv
module uart_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 200;
  localparam int RXD = 32;
  localparam int TXD = 16;

  logic       clk, rst_n;
  logic       rx_in_valid, rx_in_ready;
  logic [7:0] rx_in_data;
  logic       tx_out_valid, tx_out_ready;
  logic [7:0] tx_out_data;
  logic       sw_tx_push, sw_rx_pop;
  logic [7:0] sw_tx_data, sw_rx_data;
  logic [5:0] rx_level;
  logic [4:0] tx_space;
  logic       rx_flush, tx_flush, ovf_clear, rx_ovf, tx_ovf;
  logic [4:0] rx_trig, afc_level;
  logic [3:0] tx_trig;
  logic       rx_avail, tx_need, afc_en, sw_rts, rts_n;

  int n_chk = 0;
  int n_fail = 0;

  uart_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .sw_tx_push(sw_tx_push), .sw_tx_data(sw_tx_data),
    .sw_rx_pop(sw_rx_pop), .sw_rx_data(sw_rx_data),
    .rx_level(rx_level), .tx_space(tx_space),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .ovf_clear(ovf_clear),
    .rx_ovf(rx_ovf), .tx_ovf(tx_ovf),
    .rx_trig(rx_trig), .tx_trig(tx_trig),
    .rx_avail(rx_avail), .tx_need(tx_need),
    .afc_en(afc_en), .afc_level(afc_level), .sw_rts(sw_rts), .rts_n(rts_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rxb(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] txb(input int i);
    return 8'((i * 53 + 90) & 255);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Each task starts and ends just after a falling edge
  task automatic rx_put(input logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic rx_take();
    sw_rx_pop = 1'b1;
    @(negedge clk);
    sw_rx_pop = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] d);
    sw_tx_push = 1'b1; sw_tx_data = d;
    @(negedge clk);
    sw_tx_push = 1'b0;
  endtask

  task automatic pulse_clear();
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
  endtask

  // Sweep every receive threshold and every flow-control level
  task automatic rx_sweep(input int lvl);
    for (int t = 0; t < RXD; t++) begin
      rx_trig = 5'(t); #1;
      chk(int'(rx_avail), int'(lvl > t), "R4 rx_avail");
    end
    afc_en = 1'b1;
    for (int a = 0; a < RXD; a++) begin
      afc_level = 5'(a); #1;
      chk(int'(rts_n), int'(lvl > a), "R6 rts_n");
    end
    afc_en = 1'b0; rx_trig = '0; afc_level = '0;
  endtask

  task automatic tx_sweep(input int pend);
    for (int t = 0; t < TXD; t++) begin
      tx_trig = 4'(t); #1;
      chk(int'(tx_need), int'(pend <= t), "R5 tx_need");
    end
    tx_trig = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_in_valid = 0; rx_in_data = 0; tx_out_ready = 0;
    sw_tx_push = 0; sw_tx_data = 0; sw_rx_pop = 0;
    rx_flush = 0; tx_flush = 0; ovf_clear = 0;
    rx_trig = 0; tx_trig = 0; afc_en = 0; afc_level = 0; sw_rts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(int'(rx_level), 0, "R1 rx_level");
    chk(int'(tx_space), TXD, "R1 tx_space");
    chk(int'(rx_ovf), 0, "R1 rx_ovf");
    chk(int'(tx_ovf), 0, "R1 tx_ovf");
    chk(int'(tx_out_valid), 0, "R1 tx_out_valid");
    chk(int'(rx_in_ready), 1, "R1 rx_in_ready");

    // R7 software RTS
    sw_rts = 1'b0; #1; chk(int'(rts_n), 1, "R7 rts_n sw0");
    sw_rts = 1'b1; #1; chk(int'(rts_n), 0, "R7 rts_n sw1");
    sw_rts = 1'b0;

    // R12 pops on empty queues
    sw_rx_pop = 1'b1; tx_out_ready = 1'b1;
    @(negedge clk);
    sw_rx_pop = 1'b0; tx_out_ready = 1'b0;
    chk(int'(rx_level), 0, "R12 rx_level after empty pop");
    chk(int'(tx_space), TXD, "R12 tx_space after empty pop");
    chk(int'(tx_out_valid), 0, "R12 tx_out_valid empty");

    // R2/R4/R6 fill receive queue level by level
    for (int lvl = 0; lvl <= RXD; lvl++) begin
      if (lvl > 0) rx_put(rxb(lvl - 1));
      chk(int'(rx_level), lvl, "R2 rx_level fill");
      chk(int'(rx_in_ready), int'(lvl < RXD), "R12 rx_in_ready");
      rx_sweep(lvl);
    end
    sw_rts = 1'b1; #1; chk(int'(rts_n), 0, "R7 rts_n with full queue");
    sw_rts = 1'b0;

    // R10 receive overflow
    chk(int'(rx_ovf), 0, "R10 rx_ovf before loss");
    rx_put(8'hAA);
    rx_put(8'hBB);
    chk(int'(rx_ovf), 1, "R10 rx_ovf");
    chk(int'(rx_level), RXD, "R10 rx_level after loss");

    // R2 drain in order; dropped bytes never appear
    for (int i = 0; i < RXD; i++) begin
      chk(int'(sw_rx_data), int'(rxb(i)), "R2 rx order");
      rx_take();
      chk(int'(rx_level), RXD - 1 - i, "R2 rx_level drain");
    end
    chk(int'(rx_ovf), 1, "R11 rx_ovf sticky");

    // R2 simultaneous push and pop
    for (int i = 100; i < 103; i++) rx_put(rxb(i));
    rx_in_valid = 1'b1; rx_in_data = rxb(103); sw_rx_pop = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0; sw_rx_pop = 1'b0;
    chk(int'(rx_level), 3, "R2 level push+pop");
    for (int i = 101; i < 104; i++) begin
      chk(int'(sw_rx_data), int'(rxb(i)), "R2 order after push+pop");
      rx_take();
    end

    // R8/R11 flush with simultaneous push, flag kept
    for (int i = 0; i < 5; i++) rx_put(rxb(50 + i));
    rx_flush = 1'b1; rx_in_valid = 1'b1; rx_in_data = 8'h11;
    @(negedge clk);
    rx_flush = 1'b0; rx_in_valid = 1'b0;
    chk(int'(rx_level), 0, "R8 rx flush");
    chk(int'(rx_ovf), 1, "R11 rx_ovf kept over flush");
    pulse_clear();
    chk(int'(rx_ovf), 0, "R11 rx_ovf cleared");
    rx_put(rxb(200));
    chk(int'(sw_rx_data), int'(rxb(200)), "R8 rx data after flush");
    rx_take();

    // R3/R5 fill transmit queue
    for (int p = 0; p <= TXD; p++) begin
      if (p > 0) tx_put(txb(p - 1));
      chk(int'(tx_space), TXD - p, "R3 tx_space fill");
      chk(int'(tx_out_valid), int'(p > 0), "R12 tx_out_valid");
      tx_sweep(p);
    end

    // R9 transmit overflow
    tx_put(8'hCC);
    chk(int'(tx_ovf), 1, "R9 tx_ovf");
    chk(int'(tx_space), 0, "R9 tx_space after loss");

    // R3 drain in order
    for (int i = 0; i < TXD; i++) begin
      chk(int'(tx_out_valid), 1, "R3 tx_out_valid drain");
      chk(int'(tx_out_data), int'(txb(i)), "R3 tx order");
      tx_out_ready = 1'b1;
      @(negedge clk);
      tx_out_ready = 1'b0;
      chk(int'(tx_space), i + 1, "R3 tx_space drain");
    end
    chk(int'(tx_out_valid), 0, "R12 tx_out_valid after drain");
    chk(int'(tx_ovf), 1, "R11 tx_ovf sticky");

    // R11 new loss beats clear
    for (int i = 0; i < TXD; i++) tx_put(txb(i + 20));
    sw_tx_push = 1'b1; sw_tx_data = 8'hDD; ovf_clear = 1'b1;
    @(negedge clk);
    sw_tx_push = 1'b0; ovf_clear = 1'b0;
    chk(int'(tx_ovf), 1, "R11 set beats clear");
    pulse_clear();
    chk(int'(tx_ovf), 0, "R11 tx_ovf cleared");

    // R8 transmit flush with push while full: ignored, no flag
    tx_flush = 1'b1; sw_tx_push = 1'b1; sw_tx_data = 8'hEE;
    @(negedge clk);
    tx_flush = 1'b0; sw_tx_push = 1'b0;
    chk(int'(tx_space), TXD, "R8 tx flush");
    chk(int'(tx_ovf), 0, "R8 no flag on flush push");
    tx_put(txb(77));
    chk(int'(tx_out_data), int'(txb(77)), "R8 tx data after flush");

    summary();
    $finish;
  end
endmodule